// File: doc/BRIEF.md
# Memory-Mapped Legacy Register Bridge

This block gives a host a 4 KiB memory-mapped window onto the register banks of a display controller. A host request carries a 12-bit byte offset, a size of 1, 2 or 4 bytes and 32 bits of little-endian data. The bridge turns each request into a short, ordered series of transactions on one of two back-end buses. It answers with a single response pulse once every transaction in the series has finished.

The window has three mapped regions. At offset 0x400 there are 32 bytes, and each byte is routed to an 8-bit legacy I/O port at address 0x3C0 plus the byte's offset. A wide access becomes a series of byte accesses that run from the lowest address upward. Because the bytes go out in that order, an index port and the data port after it can both be loaded by one host word. At offset 0x500 there are eleven 16-bit extended-mode registers. Each access to one of them is a two-phase exchange on an index/data bus: the index is sent first, then the data is read or written. At offset 0x600 there is an optional 8-byte local bank that reports its own size and holds a frame-buffer byte-order flag. That flag changes only when the host writes one of two exact 32-bit magic words.

Top module: `mmio_legacy_bridge`

## Requirements
- R1: A host access whose first byte lies in 0x400..0x41F forwards each byte at offset 0x400+N to legacy port address 0x3C0+N on `port_addr`. A byte access makes exactly one port transaction. The port request holds its address and data until `port_ack`.
- R2: A 16-bit write to the legacy region makes two port writes. The low byte `req_wdata[7:0]` goes to the addressed port first. Then `req_wdata[15:8]` goes to the next port. So writing 0x5A03 at 0x404 selects index 3 on port 0x3C4 and then stores 0x5A through port 0x3C5 into entry 3.
- R3: A 16-bit read from the legacy region returns the addressed port in bits 7:0 and the next port in bits 15:8. Bits 31:16 are zero.
- R4: A 4-byte access to the legacy region makes four byte transactions in ascending address order. A 4-byte access to the extended region is two 16-bit accesses, the lower address first. Any byte or half that falls outside its region makes no transaction and reads zero.
- R5: The extended region covers offsets 0x500..0x515. Each 16-bit access first sends a write of index (offset-0x500)>>1 with `ext_data_phase`=0. It then performs the data read or write with `ext_data_phase`=1, using 16-bit data in lanes 15:0, or lanes 31:16 for the upper half of a 4-byte access. A 1-byte access is handled as a 16-bit access.
- R6: With `LOCAL_EN`=1, the region 0x600..0x607 exists and accepts only 4-byte (`req_size` 2 or 3) accesses at 4-byte-aligned offsets. Offset 0 reads 8. Other sizes read zero and have no effect. `rev_id` is 2 when `LOCAL_EN`=1 and 0 otherwise.
- R7: Offset 0x604 reads 0xBEBEBEBE while `big_endian` is 1 and 0x1E1E1E1E while it is 0.
- R8: `big_endian` is 0 after reset. A 4-byte write of exactly 0xBEBEBEBE to 0x604 sets it, and exactly 0x1E1E1E1E clears it. Any other value leaves it unchanged.
- R9: Offsets outside the three regions, and extended offsets 0x516 and above, read zero, ignore writes and make no back-end transaction.
- R10: While a request is in progress `busy` is 1 and new requests are not accepted. `rsp_valid` pulses for one cycle after the last transaction of the request has been acknowledged, with read data on `rsp_rdata`.
- R11: `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. All host data is little-endian, with byte k of the access in bits 8k+7:8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe, accepted when `busy` is 0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data, little-endian |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with `rsp_valid` |
| port_req | output | 1 | Legacy port transaction request |
| port_write | output | 1 | Legacy port direction |
| port_addr | output | 10 | Legacy port address |
| port_wdata | output | 8 | Legacy port write byte |
| port_rdata | input | 8 | Legacy port read byte, valid with `port_ack` |
| port_ack | input | 1 | Legacy port transaction done |
| ext_req | output | 1 | Extended bus request |
| ext_data_phase | output | 1 | 0 = index phase, 1 = data phase |
| ext_write | output | 1 | Extended bus direction (1 in index phase) |
| ext_wdata | output | 16 | Index or write data |
| ext_rdata | input | 16 | Extended read data, valid with `ext_ack` |
| ext_ack | input | 1 | Extended bus phase done |
| big_endian | output | 1 | Frame-buffer byte-order flag |
| rev_id | output | 8 | Revision identifier |

## Verification
Most internal faults show up at the ports within one request. If the byte counter or the unit order is wrong, the index/data pair is loaded out of order, and the wrong entry reads back on the next access to that pair. A wrong region decode shows up as a transaction count that changes on an access that should have none, or as a read that is not zero. If the byte-order flag is corrupted, `big_endian` shows it in the cycle after the write, and the next read of 0x604 returns the wrong magic word. A sequencer that hangs keeps `busy` high and never produces the response pulse.

// File: rtl/mmio_legacy_bridge.sv
module mmio_legacy_bridge #(
  parameter int          LOCAL_EN  = 1,
  parameter logic [11:0] LEG_BASE  = 12'h400,
  parameter int          LEG_BYTES = 32,
  parameter logic [11:0] EXT_BASE  = 12'h500,
  parameter int          EXT_REGS  = 11,
  parameter logic [11:0] LOC_BASE  = 12'h600,
  parameter logic [9:0]  PORT_BASE = 10'h3C0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        busy,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        port_req,
  output logic        port_write,
  output logic [9:0]  port_addr,
  output logic [7:0]  port_wdata,
  input  logic [7:0]  port_rdata,
  input  logic        port_ack,
  output logic        ext_req,
  output logic        ext_data_phase,
  output logic        ext_write,
  output logic [15:0] ext_wdata,
  input  logic [15:0] ext_rdata,
  input  logic        ext_ack,
  output logic        big_endian,
  output logic [7:0]  rev_id
);
  localparam logic [12:0] LEG_END = 13'(LEG_BASE) + 13'(LEG_BYTES);
  localparam logic [12:0] EXT_END = 13'(EXT_BASE) + 13'(2 * EXT_REGS);
  localparam logic [12:0] LOC_END = 13'(LOC_BASE) + 13'd8;
  localparam logic [31:0] MAGIC_BE = 32'hBEBEBEBE;
  localparam logic [31:0] MAGIC_LE = 32'h1E1E1E1E;

  typedef enum logic [2:0] {S_IDLE, S_PORT, S_EIDX, S_EDAT, S_DONE} state_t;

  state_t      st;
  logic        wr_q, be_q;
  logic [11:0] addr_q;
  logic [31:0] wdata_q, rdata_q;
  logic [1:0]  k, last_q;

  logic        in_leg, in_ext, in_loc, loc_ok;
  logic [11:0] loc_off, leg_a, leg_off, ext_a, ext_off;
  logic        leg_hit, ext_hit;

  assign in_leg  = ({1'b0, req_addr} >= 13'(LEG_BASE)) && ({1'b0, req_addr} < LEG_END);
  assign in_ext  = ({1'b0, req_addr} >= 13'(EXT_BASE)) && ({1'b0, req_addr} < EXT_END);
  assign in_loc  = (LOCAL_EN != 0) && ({1'b0, req_addr} >= 13'(LOC_BASE)) && ({1'b0, req_addr} < LOC_END);
  assign loc_off = req_addr - LOC_BASE;
  assign loc_ok  = req_size[1] && (req_addr[1:0] == 2'b00);

  assign leg_a   = addr_q + {10'b0, k};
  assign leg_off = leg_a - LEG_BASE;
  assign leg_hit = ({1'b0, leg_a} >= 13'(LEG_BASE)) && ({1'b0, leg_a} < LEG_END);
  assign ext_a   = addr_q + {9'b0, k, 1'b0};
  assign ext_off = ext_a - EXT_BASE;
  assign ext_hit = ({1'b0, ext_a} >= 13'(EXT_BASE)) && ({1'b0, ext_a} < EXT_END);

  assign busy       = (st != S_IDLE);
  assign rsp_valid  = (st == S_DONE);
  assign rsp_rdata  = rdata_q;
  assign big_endian = be_q;
  assign rev_id     = (LOCAL_EN != 0) ? 8'd2 : 8'd0;

  assign port_req   = (st == S_PORT) && leg_hit;
  assign port_write = wr_q;
  assign port_addr  = PORT_BASE + leg_off[9:0];
  assign port_wdata = wdata_q[{k, 3'b000} +: 8];

  assign ext_data_phase = (st == S_EDAT);
  assign ext_req        = ((st == S_EIDX) && ext_hit) || (st == S_EDAT);
  assign ext_write      = ext_data_phase ? wr_q : 1'b1;
  assign ext_wdata      = ext_data_phase ? wdata_q[{k[0], 4'b0000} +: 16] : {5'b0, ext_off[11:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      wr_q    <= 1'b0;
      be_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      k       <= '0;
      last_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          wr_q    <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          rdata_q <= '0;
          k       <= '0;
          if (in_leg) begin
            st     <= S_PORT;
            last_q <= req_size[1] ? 2'd3 : {1'b0, req_size[0]};
          end else if (in_ext) begin
            st     <= S_EIDX;
            last_q <= {1'b0, req_size[1]};
          end else begin
            st <= S_DONE;
            if (in_loc && loc_ok) begin
              if (!req_write)
                rdata_q <= loc_off[2] ? (be_q ? MAGIC_BE : MAGIC_LE) : 32'd8;
              else if (loc_off[2]) begin
                if (req_wdata == MAGIC_BE)      be_q <= 1'b1;
                else if (req_wdata == MAGIC_LE) be_q <= 1'b0;
              end
            end
          end
        end
        S_PORT: if (!leg_hit || port_ack) begin
          if (leg_hit && !wr_q) rdata_q[{k, 3'b000} +: 8] <= port_rdata;
          if (k == last_q) st <= S_DONE;
          else k <= k + 2'd1;
        end
        S_EIDX: if (!ext_hit) begin
          if (k == last_q) st <= S_DONE;
          else k <= k + 2'd1;
        end else if (ext_ack) st <= S_EDAT;
        S_EDAT: if (ext_ack) begin
          if (!wr_q) rdata_q[{k[0], 4'b0000} +: 16] <= ext_rdata;
          if (k == last_q) st <= S_DONE;
          else begin
            k  <= k + 2'd1;
            st <= S_EIDX;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_port_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    port_req && !port_ack |=> port_req && $stable(port_addr) && $stable(port_wdata));

  p_index_then_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && !ext_data_phase && ext_ack |=> ext_req && ext_data_phase);

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !port_req && !ext_req && busy);

  p_be_magic_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (big_endian != $past(big_endian)) |->
      $past(req_valid && !busy && req_write && req_size[1] &&
            req_addr == LOC_BASE + 12'd4 &&
            (req_wdata == MAGIC_BE || req_wdata == MAGIC_LE)));
endmodule

// File: tb/mmio_legacy_bridge_tb_top.sv
`timescale 1ns/100ps
module mmio_legacy_bridge_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [11:0] req_addr = 0;
  logic [1:0]  req_size = 0;
  logic [31:0] req_wdata = 0;
  logic        busy, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        port_req, port_write, port_ack;
  logic [9:0]  port_addr;
  logic [7:0]  port_wdata, port_rdata;
  logic        ext_req, ext_data_phase, ext_write, ext_ack;
  logic [15:0] ext_wdata, ext_rdata;
  logic        big_endian;
  logic [7:0]  rev_id;

  mmio_legacy_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .port_req(port_req), .port_write(port_write), .port_addr(port_addr),
    .port_wdata(port_wdata), .port_rdata(port_rdata), .port_ack(port_ack),
    .ext_req(ext_req), .ext_data_phase(ext_data_phase), .ext_write(ext_write),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ack(ext_ack),
    .big_endian(big_endian), .rev_id(rev_id));

  // back-end models: legacy port 0x3C4/0x3C5 act as an index/data pair
  logic [7:0]  leg_mem [32];
  logic [7:0]  seq_mem [8];
  logic [15:0] ext_mem [16];
  logic [3:0]  e_idx;
  int pcnt, ecnt, port_txn, ext_txn;

  always @(posedge clk) begin
    if (!rst_n) begin
      port_ack <= 0; port_rdata <= 0; pcnt <= 0;
    end else if (port_req && !port_ack) begin
      if (pcnt == 0) begin
        port_ack <= 1;
        pcnt <= $urandom % 3;
        port_txn <= port_txn + 1;
        if (port_write) begin
          if (port_addr == 10'h3C5) seq_mem[leg_mem[4][2:0]] <= port_wdata;
          else leg_mem[port_addr - 10'h3C0] <= port_wdata;
        end else
          port_rdata <= (port_addr == 10'h3C5) ? seq_mem[leg_mem[4][2:0]] : leg_mem[port_addr - 10'h3C0];
      end else pcnt <= pcnt - 1;
    end else port_ack <= 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      ext_ack <= 0; ext_rdata <= 0; ecnt <= 0; e_idx <= 0;
    end else if (ext_req && !ext_ack) begin
      if (ecnt == 0) begin
        ext_ack <= 1;
        ecnt <= $urandom % 3;
        ext_txn <= ext_txn + 1;
        if (!ext_data_phase) e_idx <= ext_wdata[3:0];
        else if (ext_write) ext_mem[e_idx] <= ext_wdata;
        else ext_rdata <= ext_mem[e_idx];
      end else ecnt <= ecnt - 1;
    end else ext_ack <= 0;
  end

  // expectation shadows
  logic [7:0]  sh_leg [32];
  logic [7:0]  sh_seq [8];
  logic [15:0] sh_ext [11];
  logic        sh_be;
  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return sz[1] ? 4 : (sz[0] ? 2 : 1);
  endfunction

  task automatic predict(input logic w, input logic [11:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, output logic [31:0] exp);
    exp = 0;
    if (a >= 12'h400 && a < 12'h420) begin
      for (int i = 0; i < nbytes(sz); i++) begin
        logic [11:0] b;
        b = a + 12'(i);
        if (b >= 12'h400 && b < 12'h420) begin
          if (w) begin
            if (b == 12'h405) sh_seq[sh_leg[4][2:0]] = wd[8*i +: 8];
            else sh_leg[b - 12'h400] = wd[8*i +: 8];
          end else
            exp[8*i +: 8] = (b == 12'h405) ? sh_seq[sh_leg[4][2:0]] : sh_leg[b - 12'h400];
        end
      end
    end else if (a >= 12'h500 && a < 12'h516) begin
      for (int i = 0; i < (sz[1] ? 2 : 1); i++) begin
        logic [11:0] b;
        b = a + 12'(2 * i);
        if (b >= 12'h500 && b < 12'h516) begin
          if (w) sh_ext[(b - 12'h500) >> 1] = wd[16*i +: 16];
          else exp[16*i +: 16] = sh_ext[(b - 12'h500) >> 1];
        end
      end
    end else if (a >= 12'h600 && a < 12'h608 && sz[1] && a[1:0] == 0) begin
      if (!w) exp = a[2] ? (sh_be ? 32'hBEBEBEBE : 32'h1E1E1E1E) : 32'd8;
      else if (a[2]) begin
        if (wd == 32'hBEBEBEBE) sh_be = 1;
        else if (wd == 32'h1E1E1E1E) sh_be = 0;
      end
    end
  endtask

  task automatic access(input logic w, input logic [11:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    int n;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
    @(posedge clk);
    n = 0;
    rd = 32'hDEADDEAD;
    while (n < 500) begin
      @(negedge clk);
      req_valid = 0;
      if (rsp_valid) begin rd = rsp_rdata; break; end
      n++;
    end
    if (n == 500) chk("R10 response arrives", 0, 1);
  endtask

  task automatic op(input string req, input logic w, input logic [11:0] a,
                    input logic [1:0] sz, input logic [31:0] wd);
    logic [31:0] e, r;
    predict(w, a, sz, wd, e);
    access(w, a, sz, wd, r);
    if (!w) chk(req, r, e);
    chk({req, " R8 flag"}, {31'b0, big_endian}, {31'b0, sh_be});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int t0;
    logic [31:0] r;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) begin leg_mem[i] = 0; sh_leg[i] = 0; end
    for (int i = 0; i < 8; i++) begin seq_mem[i] = 0; sh_seq[i] = 0; end
    for (int i = 0; i < 16; i++) ext_mem[i] = 0;
    for (int i = 0; i < 11; i++) sh_ext[i] = 0;
    sh_be = 0; port_txn = 0; ext_txn = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 reset busy", {31'b0, busy}, 0);
    chk("R10 reset rsp_valid", {31'b0, rsp_valid}, 0);
    chk("R8 reset flag", {31'b0, big_endian}, 0);
    chk("R6 rev_id", {24'b0, rev_id}, 32'd2);
    chk("R1 reset idle buses", {30'b0, port_req, ext_req}, 0);
    rst_n = 1;

    // R2: one word loads index then data
    op("R2 word write", 1, 12'h404, 2'd1, 32'h0000_5A03);
    chk("R2 index port", {24'b0, leg_mem[4]}, 32'h03);
    chk("R2 data entry", {24'b0, seq_mem[3]}, 32'h5A);
    op("R3 word read", 0, 12'h404, 2'd1, 0);
    // R1: last byte maps to port 0x3DF
    op("R1 byte write", 1, 12'h41F, 2'd0, 32'h0000_00C7);
    chk("R1 port 0x3DF", {24'b0, leg_mem[31]}, 32'hC7);
    op("R4 R11 legacy dword write", 1, 12'h408, 2'd2, 32'h4433_2211);
    chk("R4 R11 byte order", {leg_mem[11], leg_mem[10], leg_mem[9], leg_mem[8]}, 32'h4433_2211);
    op("R4 legacy dword read past end", 0, 12'h41E, 2'd2, 0);
    // R5: extended dword
    op("R5 ext dword write", 1, 12'h504, 2'd2, 32'hBEEF_1234);
    chk("R5 low half index 2", {16'b0, ext_mem[2]}, 32'h1234);
    chk("R5 high half index 3", {16'b0, ext_mem[3]}, 32'hBEEF);
    op("R5 ext read", 0, 12'h504, 2'd2, 0);
    op("R5 last ext reg", 1, 12'h514, 2'd1, 32'h0000_7777);
    chk("R5 index 10", {16'b0, ext_mem[10]}, 32'h7777);
    // R6..R8 local bank
    op("R6 size reg", 0, 12'h600, 2'd2, 0);
    op("R6 half-size read zero", 0, 12'h600, 2'd1, 0);
    op("R7 order reg LE", 0, 12'h604, 2'd2, 0);
    op("R8 near-magic ignored", 1, 12'h604, 2'd2, 32'hBEBEBEBF);
    op("R8 set BE", 1, 12'h604, 2'd2, 32'hBEBEBEBE);
    op("R7 order reg BE", 0, 12'h604, 2'd2, 0);
    op("R8 other ignored", 1, 12'h604, 2'd2, 32'h0000_0000);
    op("R8 clear", 1, 12'h604, 2'd2, 32'h1E1E1E1E);
    // R9: unmapped, no bus traffic
    t0 = port_txn + ext_txn;
    op("R9 unmapped write", 1, 12'h100, 2'd2, 32'hFFFF_FFFF);
    op("R9 unmapped read", 0, 12'h100, 2'd2, 0);
    op("R9 ext beyond regs", 1, 12'h516, 2'd1, 32'h1111);
    op("R9 ext beyond read", 0, 12'h516, 2'd1, 0);
    chk("R9 no transactions", port_txn + ext_txn, t0);

    for (int i = 0; i < 400; i++) begin
      int reg_sel;
      logic [11:0] a;
      logic [31:0] wd;
      logic w;
      reg_sel = $urandom % 4;
      w = $urandom % 2;
      wd = $urandom;
      case (reg_sel)
        0: a = 12'h400 + 12'($urandom % 34);
        1: a = 12'h500 + 12'($urandom % 26);
        2: begin
             a = 12'h600 + 12'($urandom % 8);
             if ($urandom % 2) wd = ($urandom % 2) ? 32'hBEBEBEBE : 32'h1E1E1E1E;
           end
        default: a = 12'($urandom % 4096);
      endcase
      case (reg_sel)
        0: op("R3 R4 random legacy", w, a, 2'($urandom % 4), wd);
        1: op("R5 random ext", w, a, 2'($urandom % 4), wd);
        2: op("R7 random local", w, a, 2'($urandom % 4), wd);
        default: op("R9 random any", w, a, 2'($urandom % 4), wd);
      endcase
    end
    for (int i = 0; i < 32; i++) chk("R1 legacy final", {24'b0, leg_mem[i]}, {24'b0, sh_leg[i]});
    for (int i = 0; i < 8; i++) chk("R2 pair final", {24'b0, seq_mem[i]}, {24'b0, sh_seq[i]});
    for (int i = 0; i < 11; i++) chk("R5 ext final", {16'b0, ext_mem[i]}, {16'b0, sh_ext[i]});

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule